// File: doc/BRIEF.md
# Serial-Bus Core CSR Register File

This block serves single-quadlet writes and quadlet reads, single or multi-quadlet, to the core control and status registers of a serial-bus node. The registers are the state register (set and clear views), the node identifier, the two split-timeout halves, cycle time, bus time and the broadcast-channel register. A request is accepted with `req_valid` while `req_ready` is high. It carries a byte offset inside the register space, a byte length, a direction and one write quadlet. Each answered quadlet comes back as a response beat that carries a completion code.

Cycle time is not kept as a running counter here. The link supplies a free-running `cyc_time` value. Each read of cycle time or bus time samples that value and compares it with the previous sample. This is how a wrap of the cycle timer is detected and carried into bus time. A write to cycle time is passed back to the link as a one-cycle load pulse. The block also drives the bus-ID field to the link. From the split-timeout registers it derives a split-transaction expiry, given in 125 µs cycles.

A bus-reset pulse loads the PHY node number and restores the broadcast-channel register. It also trims the state register as the node's root status requires.

Top module: `sbus_csr_regs`

## Requirements
- R1: A request whose offset or length has bit 1 or bit 0 set, or whose length is zero, gets one response beat with code 6 (type error), data 0 and `rsp_last` high.
- R2: Reads return code 7 (address error, data 0) at any offset other than 0x000, 0x004, 0x008, 0x00C, 0x018, 0x01C, 0x200, 0x204 and 0x234. This includes busy-timeout at 0x210 and the gaps between registers. A read of reset-start (0x00C) returns code 6. Both cases end the response.
- R3: A read of N quadlets produces one beat per cycle, starting in the cycle after acceptance, at offsets rising by 4. `rsp_last` is high on beat N, or on the first beat that carries a non-zero code. `req_ready` stays low until the last beat.
- R4: The node-ID register (0x008) reads as {bus ID in bits 31:22, node number in bits 21:16, zeros}. A write takes only bits 31:22 and keeps the node number. `bus_id` shows the stored bus ID. A bus reset loads the node number from `phy_node`.
- R5: A write keeps only bits 2:0 (seconds) of split-timeout-high (0x018) and only bits 31:19 (125 µs units) of split-timeout-low (0x01C). After reset the high register is 0 and the low register holds 800 in bits 31:19.
- R6: `split_expiry` equals seconds × 8000 + (low field), but never less than 800.
- R7: A read of cycle time (0x200) returns `cyc_time`. When a read of 0x200 or 0x204 sees `cyc_time` below the previous sample, bus time first grows by 128. A write to 0x200 replaces the sample and raises `cyc_load` with `cyc_load_val` equal to the write data for one cycle.
- R8: A read of bus time (0x204) returns the stored bus time OR (`cyc_time` >> 25). A write keeps only bits 31:7.
- R9: The broadcast-channel register (0x234) holds 0x8000001F after reset and after a bus reset. Writes change only bit 30.
- R10: A write to 0x004 ORs the data into the state register. A write to 0x000 clears the bits that are set in the data. Both offsets read the state register. A bus reset keeps only bits 9:8, and also clears bit 8 when `is_root` is low.
- R11: A write whose length is not 4 returns code 6. A write to an offset outside R2's list returns code 7. A write to reset-start returns code 0 and changes no register. Accepted writes answer with one beat of code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle bus-reset pulse |
| is_root | input | 1 | Node is root, sampled on bus reset |
| phy_node | input | 6 | Node number loaded on bus reset |
| cyc_time | input | 32 | Free-running cycle-time value from the link |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the register space |
| req_len | input | LEN_W | Byte length of the access |
| req_wdata | input | 32 | Write quadlet |
| rsp_valid | output | 1 | Response beat valid |
| rsp_last | output | 1 | Final beat of the response |
| rsp_code | output | 4 | 0 complete, 6 type error, 7 address error |
| rsp_data | output | 32 | Read quadlet (0 for writes and errors) |
| bus_id | output | 10 | Stored bus ID for the link |
| cyc_load | output | 1 | One-cycle pulse on a cycle-time write |
| cyc_load_val | output | 32 | Value to load into the link's cycle timer |
| split_expiry | output | 16 | Split-transaction expiry in 125 µs cycles |

## Verification
Random traffic walks every implemented offset and the gap and busy-timeout offsets, with random data. This shows that the write masks are right field by field and that gaps answer as errors rather than aliasing a neighbour. Lengths vary between one and four quadlets and are sometimes misaligned. This tells apart a correct burst stride and stop-on-error from a burst that runs too long or too short. Cycle-time inputs mostly climb and sometimes drop, so a read that must add 128 to bus time is distinguished from one that must not. Directed cases cover split-timeout values on both sides of the 800-cycle floor and the maximum sum, and bus resets with and without root status.

// File: rtl/sbus_csr_regs.sv
module sbus_csr_regs #(
  parameter int ADDR_W      = 12,
  parameter int LEN_W       = 12,
  parameter int CYC_PER_SEC = 8000,
  parameter int EXP_FLOOR   = 800,
  parameter int EXP_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              is_root,
  input  logic [5:0]        phy_node,
  input  logic [31:0]       cyc_time,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [3:0]        rsp_code,
  output logic [31:0]       rsp_data,
  output logic [9:0]        bus_id,
  output logic              cyc_load,
  output logic [31:0]       cyc_load_val,
  output logic [EXP_W-1:0]  split_expiry
);
  localparam logic [ADDR_W-1:0] OFS_ST_CLR = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_ST_SET = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_NODE   = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_RST_ST = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFS_SPL_HI = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] OFS_SPL_LO = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] OFS_CYC    = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] OFS_BTIME  = ADDR_W'(12'h204);
  localparam logic [ADDR_W-1:0] OFS_BCAST  = ADDR_W'(12'h234);
  localparam logic [3:0] RC_OK   = 4'd0;
  localparam logic [3:0] RC_TYPE = 4'd6;
  localparam logic [3:0] RC_ADDR = 4'd7;
  localparam logic [31:0] BCAST_INIT = 32'h8000_001F;
  localparam logic [12:0] SLO_INIT = 13'd800;

  logic [31:0]       state_q;
  logic [15:0]       node_q;
  logic [2:0]        shi_q;
  logic [12:0]       slo_q;
  logic [31:0]       cyc_q;
  logic [24:0]       btime_q;
  logic [31:0]       bcast_q;
  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  rem_q;

  logic              acc, bad_req, rd_act, wrap, last;
  logic [ADDR_W-1:0] a;
  logic [LEN_W-1:0]  n;
  logic [24:0]       btime_nx;
  logic [31:0]       rd_data;
  logic [3:0]        rd_code, wr_code;
  logic [EXP_W-1:0]  exp_sum;

  assign req_ready = !busy_q;
  assign acc       = req_valid && !busy_q;
  assign bad_req   = (req_addr[1:0] != 2'b00) || (req_len[1:0] != 2'b00) || (req_len == '0);
  assign rd_act    = busy_q || (acc && !req_write && !bad_req);
  assign a         = busy_q ? cur_q : req_addr;
  assign n         = busy_q ? rem_q : (req_len >> 2);
  assign wrap      = cyc_time < cyc_q;
  assign btime_nx  = btime_q + (wrap ? 25'd1 : 25'd0);
  assign bus_id    = node_q[15:6];
  assign exp_sum   = EXP_W'(shi_q) * EXP_W'(CYC_PER_SEC) + EXP_W'(slo_q);
  assign split_expiry = (exp_sum < EXP_W'(EXP_FLOOR)) ? EXP_W'(EXP_FLOOR) : exp_sum;
  assign last      = (rd_code != RC_OK) || (n == LEN_W'(1));

  always_comb begin
    rd_code = RC_OK;
    rd_data = '0;
    case (a)
      OFS_ST_CLR, OFS_ST_SET: rd_data = state_q;
      OFS_NODE:   rd_data = {node_q, 16'h0000};
      OFS_RST_ST: rd_code = RC_TYPE;
      OFS_SPL_HI: rd_data = {29'd0, shi_q};
      OFS_SPL_LO: rd_data = {slo_q, 19'd0};
      OFS_CYC:    rd_data = cyc_time;
      OFS_BTIME:  rd_data = {btime_nx, 7'd0} | (cyc_time >> 25);
      OFS_BCAST:  rd_data = bcast_q;
      default:    rd_code = RC_ADDR;
    endcase
  end

  always_comb begin
    if (bad_req || req_len != LEN_W'(4)) wr_code = RC_TYPE;
    else begin
      case (req_addr)
        OFS_ST_CLR, OFS_ST_SET, OFS_NODE, OFS_RST_ST, OFS_SPL_HI,
        OFS_SPL_LO, OFS_CYC, OFS_BTIME, OFS_BCAST: wr_code = RC_OK;
        default: wr_code = RC_ADDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      node_q <= '0;
      shi_q <= '0;
      slo_q <= SLO_INIT;
      cyc_q <= '0;
      btime_q <= '0;
      bcast_q <= BCAST_INIT;
      busy_q <= 1'b0;
      cur_q <= '0;
      rem_q <= '0;
      rsp_valid <= 1'b0;
      rsp_last <= 1'b0;
      rsp_code <= RC_OK;
      rsp_data <= '0;
      cyc_load <= 1'b0;
      cyc_load_val <= '0;
    end else begin
      rsp_valid <= 1'b0;
      cyc_load <= 1'b0;
      if (rd_act) begin
        rsp_valid <= 1'b1;
        rsp_data <= rd_data;
        rsp_code <= rd_code;
        rsp_last <= last;
        busy_q <= !last;
        cur_q <= a + ADDR_W'(4);
        rem_q <= n - LEN_W'(1);
        if (a == OFS_CYC || a == OFS_BTIME) begin
          cyc_q <= cyc_time;
          btime_q <= btime_nx;
        end
      end else if (acc) begin
        rsp_valid <= 1'b1;
        rsp_last <= 1'b1;
        rsp_data <= '0;
        rsp_code <= wr_code;
        if (wr_code == RC_OK) begin
          case (req_addr)
            OFS_ST_CLR: state_q <= state_q & ~req_wdata;
            OFS_ST_SET: state_q <= state_q | req_wdata;
            OFS_NODE:   node_q[15:6] <= req_wdata[31:22];
            OFS_SPL_HI: shi_q <= req_wdata[2:0];
            OFS_SPL_LO: slo_q <= req_wdata[31:19];
            OFS_CYC: begin
              cyc_q <= req_wdata;
              cyc_load <= 1'b1;
              cyc_load_val <= req_wdata;
            end
            OFS_BTIME:  btime_q <= req_wdata[31:7];
            OFS_BCAST:  bcast_q[30] <= req_wdata[30];
            default: ;
          endcase
        end
      end
      if (bus_reset) begin
        state_q <= {22'd0, state_q[9], state_q[8] & is_root, 8'd0};
        node_q[5:0] <= phy_node;
        bcast_q <= BCAST_INIT;
      end
    end
  end
endmodule

// File: rtl/sbus_csr_regs_chk.sv
module sbus_csr_regs_chk #(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = 12,
  parameter int EXP_FLOOR = 800,
  parameter int EXP_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic [3:0]        rsp_code,
  input logic [5:0]        node_num,
  input logic [31:0]       bcast,
  input logic [EXP_W-1:0]  split_expiry
);
  AST_MISALIGN_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_addr[1:0] != 2'b00 || req_len[1:0] != 2'b00))
    |=> (rsp_valid && rsp_last && rsp_code == 4'd6)); // R1
  AST_ERROR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 4'd0) |-> rsp_last); // R2
  AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |-> !req_ready); // R3
  AST_NODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset |=> $stable(node_num)); // R4
  AST_EXPIRY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    split_expiry >= EXP_W'(EXP_FLOOR)); // R6
  AST_BCAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bcast & 32'hBFFF_FFFF)); // R9
endmodule

bind sbus_csr_regs sbus_csr_regs_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .EXP_FLOOR(EXP_FLOOR), .EXP_W(EXP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
  .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_code(rsp_code),
  .node_num(node_q[5:0]), .bcast(bcast_q), .split_expiry(split_expiry)
);

// File: tb/tb_sbus_csr_regs.sv
`timescale 1ns/1ps
module tb_sbus_csr_regs;
  logic clk = 0, rst_n = 0, bus_reset = 0, is_root = 0;
  logic [5:0] phy_node = 0;
  logic [31:0] cyc_time = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0, req_len = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_last, cyc_load;
  logic [3:0] rsp_code;
  logic [31:0] rsp_data, cyc_load_val;
  logic [9:0] bus_id;
  logic [15:0] split_expiry;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_state, m_bt, m_bc, m_cyc;
  logic [15:0] m_node;
  logic [2:0] m_shi;
  logic [12:0] m_slo;

  sbus_csr_regs dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h000, 12'h004: return "R10";
      12'h008: return "R4";
      12'h00C: return "R11";
      12'h018, 12'h01C: return "R5";
      12'h200: return "R7";
      12'h204: return "R8";
      12'h234: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic model_read(input logic [11:0] a, output logic [3:0] c, output logic [31:0] d);
    c = 0; d = 0;
    case (a)
      12'h000, 12'h004: d = m_state;
      12'h008: d = {m_node, 16'h0};
      12'h00C: c = 6;
      12'h018: d = {29'd0, m_shi};
      12'h01C: d = {m_slo, 19'd0};
      12'h200, 12'h204: begin
        if (cyc_time < m_cyc) m_bt = m_bt + 32'd128;
        m_cyc = cyc_time;
        d = (a == 12'h200) ? cyc_time : (m_bt | (cyc_time >> 25));
      end
      12'h234: d = m_bc;
      default: c = 7;
    endcase
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] w, output logic [3:0] c);
    c = 0;
    case (a)
      12'h000: m_state = m_state & ~w;
      12'h004: m_state = m_state | w;
      12'h008: m_node[15:6] = w[31:22];
      12'h00C: ;
      12'h018: m_shi = w[2:0];
      12'h01C: m_slo = w[31:19];
      12'h200: m_cyc = w;
      12'h204: m_bt = w & 32'hFFFF_FF80;
      12'h234: m_bc = {m_bc[31], w[30], m_bc[29:0]};
      default: c = 7;
    endcase
  endtask

  function automatic logic [15:0] exp_expiry();
    int s;
    s = m_shi * 8000 + m_slo;
    return (s < 800) ? 16'd800 : 16'(s);
  endfunction

  task automatic do_req(input bit wr, input logic [11:0] a, input logic [11:0] len, input logic [31:0] w);
    logic [3:0] ec;
    logic [31:0] ed;
    bit el, bad;
    int nq;
    string tg;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = len; req_wdata = w;
    bad = (a[1:0] != 0) || (len[1:0] != 0) || (len == 0);
    nq = len >> 2;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (bad) begin ec = 6; ed = 0; el = 1; tg = "R1"; end
      else if (wr) begin
        tg = (len != 4) ? "R11" : tag_of(a);
        if (len != 4) ec = 6; else model_write(a, w, ec);
        if (ec == 7) tg = "R11";
        ed = 0; el = 1;
        if (ec == 0 && a == 12'h200)
          chk(cyc_load && cyc_load_val == w, "R7 cycle load pulse", cyc_load_val, w);
      end else begin
        model_read(a + 12'(4 * i), ec, ed);
        tg = tag_of(a + 12'(4 * i));
        el = (ec != 0) || (i == nq - 1);
      end
      chk(rsp_valid && rsp_code == ec, {tg, " code"}, {28'd0, rsp_code}, {28'd0, ec});
      chk(rsp_data == ed, {tg, " data"}, rsp_data, ed);
      chk(rsp_last == el, "R3 last flag", {31'd0, rsp_last}, {31'd0, el});
      if (el || rsp_last) break;
    end
    chk(split_expiry == exp_expiry(), "R6 expiry", {16'd0, split_expiry}, {16'd0, exp_expiry()});
    chk(bus_id == m_node[15:6], "R4 bus id", {22'd0, bus_id}, {22'd0, m_node[15:6]});
  endtask

  task automatic do_bus_reset(input bit root, input logic [5:0] nd);
    @(negedge clk);
    bus_reset = 1; is_root = root; phy_node = nd;
    @(negedge clk);
    bus_reset = 0;
    m_state = {22'd0, m_state[9], m_state[8] & root, 8'd0};
    m_node[5:0] = nd;
    m_bc = 32'h8000_001F;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] ofs [14];
    ofs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h018, 12'h01C,
            12'h020, 12'h200, 12'h204, 12'h208, 12'h210, 12'h21C, 12'h234};
    m_state = 0; m_node = 0; m_shi = 0; m_slo = 800; m_cyc = 0; m_bt = 0; m_bc = 32'h8000_001F;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready && !cyc_load, "R3 reset idle", {31'd0, rsp_valid}, 0);
    chk(split_expiry == 16'd800, "R5 reset expiry", {16'd0, split_expiry}, 800);
    // R9 broadcast reset value and valid bit
    do_req(0, 12'h234, 4, 0);
    do_req(1, 12'h234, 4, 32'hFFFF_FFFF);
    do_req(0, 12'h234, 4, 0);
    // R1 misaligned and empty
    do_req(0, 12'h002, 4, 0);
    do_req(0, 12'h008, 6, 0);
    do_req(1, 12'h018, 0, 0);
    // R2 errors
    do_req(0, 12'h00C, 4, 0);
    do_req(0, 12'h010, 4, 0);
    do_req(0, 12'h210, 4, 0);
    // R4 node and bus reset
    do_bus_reset(0, 6'h15);
    do_req(1, 12'h008, 4, 32'hFFFF_FFFF);
    do_req(0, 12'h008, 4, 0);
    // R5 R6 split timeout
    do_req(1, 12'h018, 4, 32'hFFFF_FFFF);
    do_req(1, 12'h01C, 4, 32'hFFFF_FFFF);
    do_req(0, 12'h018, 8, 0);
    do_req(1, 12'h018, 4, 0);
    do_req(1, 12'h01C, 4, 32'd5 << 19);
    do_req(1, 12'h01C, 4, 32'd900 << 19);
    // R3 burst across gap
    do_req(0, 12'h018, 16, 0);
    do_req(0, 12'h000, 12, 0);
    // R7 R8 wrap
    cyc_time = 32'h1000_0000;
    do_req(0, 12'h200, 4, 0);
    cyc_time = 32'h0800_0000;
    do_req(0, 12'h204, 4, 0);
    do_req(0, 12'h200, 8, 0);
    do_req(1, 12'h204, 4, 32'hFFFF_FFFF);
    do_req(0, 12'h204, 4, 0);
    do_req(1, 12'h200, 4, 32'h0123_4567);
    // R10 state and root handling
    do_req(1, 12'h004, 4, 32'h0000_0F31);
    do_req(1, 12'h000, 4, 32'h0000_0010);
    do_req(0, 12'h000, 8, 0);
    do_bus_reset(1, 6'h02);
    do_req(0, 12'h004, 4, 0);
    do_bus_reset(0, 6'h03);
    do_req(0, 12'h004, 4, 0);
    // R11 write errors
    do_req(1, 12'h004, 8, 32'hFFFF_FFFF);
    do_req(1, 12'h210, 4, 32'hFFFF_FFFF);
    do_req(1, 12'h00C, 4, 32'hFFFF_FFFF);
    do_req(0, 12'h000, 4, 0);
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a, l;
      a = ofs[$urandom_range(0, 13)];
      l = 12'(4 * $urandom_range(1, 4));
      if ($urandom_range(0, 15) == 0) a = a + 12'($urandom_range(1, 3));
      if ($urandom_range(0, 15) == 0) l = l + 12'($urandom_range(1, 3));
      if ($urandom_range(0, 7) == 0) cyc_time = $urandom;
      else cyc_time = cyc_time + $urandom_range(0, 32'h0100_0000);
      if ($urandom_range(0, 31) == 0) do_bus_reset(1'($urandom_range(0, 1)), 6'($urandom));
      if ($urandom_range(0, 1) == 1) do_req(1, a, ($urandom_range(0, 7) == 0) ? l : 12'd4, $urandom);
      else do_req(0, a, l, 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule